// File: doc/BRIEF.md
# Exposure Window Controller

This block sets the length of a sensor exposure and drives a sync output, `integ_o`, that shows when the exposure is open. Time is counted in ticks of a slow unit clock, nominally one tick per millisecond. The unit clock arrives asynchronously to the fast system clock, so the block synchronises it first. A frame sequencer requests one exposure with a one-cycle `start_i` strobe. The block answers with a one-cycle `done_o` pulse when it is safe to move on to readout.

The exposure length comes from one of two sources. It is either a 5-bit preset code that picks one of 32 nonlinear tick counts, or an external end-of-exposure line whose rising edge closes the window. While the window is open the output is either held high for the whole window, held low, or pulsed a chosen number of times. Each pulse period lasts two ticks.

The window opens on a unit-clock edge, so preset exposures repeat exactly from frame to frame. Fixed guard gaps of two ticks come before the window opens and after it closes.

Top module: `expo_window_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no start strobe, `integ_o` and `done_o` are both low.
- R2: A unit-clock rising edge reaches the block's state three system cycles after it appears on the pin (two synchroniser flops plus one edge flop). The window starts at the first such edge seen after `start_i`. The window opens two ticks after that edge.
- R3: In internal mode (`ext_mode_i`=0) the open window lasts exactly N ticks. N comes from `expo_code_i` as follows: 0→1, 1→2, 2→3, 3→4, 4→5, 5→7, 6→10, 7→14, 8→19, 9→23, 10→39, 11→67, 12→89, 13→100, 14→125, 15→150, 16→189, 17→200, 18→250, 19→300, 20→322, 21→400, 22→489, 23→739, 24→989, 25→1489, 26→1989, 27→4989, 28→9989, 29→14989, 30→29989, 31→59989.
- R4: In external mode (`ext_mode_i`=1) the window closes three system cycles after a rising edge on `ext_end_i`, and `integ_o` drops at that moment.
- R5: `done_o` is a single-cycle pulse. It is observed at the second unit-clock tick edge after the window closes, and exactly once per accepted start.
- R6: With `pulse_code_i`=0, `integ_o` is high for the whole open window. With `pulse_code_i`=15, `integ_o` stays low for the whole window.
- R7: With `pulse_code_i` from 1 to 14, ticks of the window are numbered k=0,1,2,... and `integ_o` is high during tick k when k is odd and k/2 is below P. P is: 1..5→same value, 6→10, 7→20, 8→30, 9→40, 10→50, 11→75, 12→100, 13→150, 14→200.
- R8: When P exceeds the number of odd ticks in the window, pulsing is cut off at the window end and the done timing of R5 is unchanged.
- R9: The mode inputs are captured at the accepted start. A `start_i` or mode change during a running exposure has no effect on that exposure and does not start another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to run one exposure |
| unit_clk_i | input | 1 | Asynchronous unit-time clock; each rising edge is one tick |
| ext_end_i | input | 1 | Asynchronous end-of-exposure line, used in external mode |
| ext_mode_i | input | 1 | 1 = external end, 0 = preset length |
| expo_code_i | input | 5 | Preset exposure length code |
| pulse_code_i | input | 4 | Output shape code (steady high, pulse count, steady low) |
| integ_o | output | 1 | Exposure sync output, registered |
| done_o | output | 1 | One-cycle completion pulse, registered |

## Verification
The assertions check the following on every cycle:
- `integ_o` is low whenever no exposure is running.
- `integ_o` stays low under the steady-low code.
- `integ_o` only rises, and `done_o` only fires, right after a synchronised tick.
- `done_o` never lasts two cycles.

Only the bench scenarios can show the absolute timing: where the window lands relative to start, the exact length for each preset code, the pulse counts with their truncation, the external close, and that a stray start or a mode change leaves an exposure untouched.

// File: rtl/expo_pkg.sv
package expo_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ALIGN,
    PH_LEAD,
    PH_OPEN,
    PH_TRAIL
  } phase_t;

  // Exposure length in unit ticks for each preset code.
  function automatic logic [15:0] preset_ticks(input logic [4:0] code);
    case (code)
      5'd0:  preset_ticks = 16'd1;
      5'd1:  preset_ticks = 16'd2;
      5'd2:  preset_ticks = 16'd3;
      5'd3:  preset_ticks = 16'd4;
      5'd4:  preset_ticks = 16'd5;
      5'd5:  preset_ticks = 16'd7;
      5'd6:  preset_ticks = 16'd10;
      5'd7:  preset_ticks = 16'd14;
      5'd8:  preset_ticks = 16'd19;
      5'd9:  preset_ticks = 16'd23;
      5'd10: preset_ticks = 16'd39;
      5'd11: preset_ticks = 16'd67;
      5'd12: preset_ticks = 16'd89;
      5'd13: preset_ticks = 16'd100;
      5'd14: preset_ticks = 16'd125;
      5'd15: preset_ticks = 16'd150;
      5'd16: preset_ticks = 16'd189;
      5'd17: preset_ticks = 16'd200;
      5'd18: preset_ticks = 16'd250;
      5'd19: preset_ticks = 16'd300;
      5'd20: preset_ticks = 16'd322;
      5'd21: preset_ticks = 16'd400;
      5'd22: preset_ticks = 16'd489;
      5'd23: preset_ticks = 16'd739;
      5'd24: preset_ticks = 16'd989;
      5'd25: preset_ticks = 16'd1489;
      5'd26: preset_ticks = 16'd1989;
      5'd27: preset_ticks = 16'd4989;
      5'd28: preset_ticks = 16'd9989;
      5'd29: preset_ticks = 16'd14989;
      5'd30: preset_ticks = 16'd29989;
      default: preset_ticks = 16'd59989;
    endcase
  endfunction

  // Pulse count for the pulsing codes; steady codes 0 and 15 return zero.
  function automatic logic [7:0] pulse_total(input logic [3:0] code);
    case (code)
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5: pulse_total = {4'd0, code};
      4'd6:  pulse_total = 8'd10;
      4'd7:  pulse_total = 8'd20;
      4'd8:  pulse_total = 8'd30;
      4'd9:  pulse_total = 8'd40;
      4'd10: pulse_total = 8'd50;
      4'd11: pulse_total = 8'd75;
      4'd12: pulse_total = 8'd100;
      4'd13: pulse_total = 8'd150;
      4'd14: pulse_total = 8'd200;
      default: pulse_total = 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/expo_edge_sync.sv
module expo_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/expo_level_gen.sv
module expo_level_gen
  import expo_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] idx,
  input  logic [3:0]       shape,
  output logic             level
);
  logic [CNT_W-1:0] period_no;
  logic [CNT_W-1:0] limit;

  assign period_no = idx >> 1;
  assign limit     = CNT_W'(pulse_total(shape));

  always_comb begin
    if (shape == 4'd0)       level = 1'b1;
    else if (shape == 4'd15) level = 1'b0;
    else                     level = idx[0] && (period_no < limit);
  end
endmodule

// File: rtl/expo_window_ctrl.sv
module expo_window_ctrl
  import expo_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int GUARD_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       unit_clk_i,
  input  logic       ext_end_i,
  input  logic       ext_mode_i,
  input  logic [4:0] expo_code_i,
  input  logic [3:0] pulse_code_i,
  output logic       integ_o,
  output logic       done_o
);
  localparam logic [CNT_W-1:0] CNT_MAX    = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] GUARD_LAST = CNT_W'(GUARD_TICKS - 1);
  localparam int               N_SYNC     = 2;

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] exp_len;
  logic             ext_q;
  logic [3:0]       pcode_q;

  logic [N_SYNC-1:0] raw_in;
  logic [N_SYNC-1:0] rise;
  logic              unit_rise;
  logic              ext_rise;

  assign raw_in = {ext_end_i, unit_clk_i};

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    expo_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_in[g]),
      .rise (rise[g])
    );
  end

  assign unit_rise = rise[0];
  assign ext_rise  = rise[1];

  logic [CNT_W-1:0] nxt;
  logic [CNT_W-1:0] lvl_idx;
  logic             lvl;
  logic             busy;
  logic             close_now;

  assign nxt     = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
  assign lvl_idx = (phase == PH_LEAD) ? '0 : nxt;
  assign busy    = (phase != PH_IDLE);

  expo_level_gen #(.CNT_W(CNT_W)) u_level (
    .idx   (lvl_idx),
    .shape (pcode_q),
    .level (lvl)
  );

  always_comb begin
    if (ext_q) close_now = ext_rise;
    else       close_now = unit_rise && (nxt == exp_len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      exp_len <= '0;
      ext_q   <= 1'b0;
      pcode_q <= 4'd0;
      integ_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start_i) begin
            ext_q   <= ext_mode_i;
            pcode_q <= pulse_code_i;
            exp_len <= CNT_W'(preset_ticks(expo_code_i));
            phase   <= PH_ALIGN;
          end
        end
        PH_ALIGN: begin
          if (unit_rise) begin
            cnt   <= '0;
            phase <= PH_LEAD;
          end
        end
        PH_LEAD: begin
          if (unit_rise) begin
            if (cnt == GUARD_LAST) begin
              cnt     <= '0;
              integ_o <= lvl;
              phase   <= PH_OPEN;
            end else begin
              cnt <= nxt;
            end
          end
        end
        PH_OPEN: begin
          if (close_now) begin
            integ_o <= 1'b0;
            cnt     <= '0;
            phase   <= PH_TRAIL;
          end else if (unit_rise) begin
            cnt     <= nxt;
            integ_o <= lvl;
          end
        end
        PH_TRAIL: begin
          if (unit_rise) begin
            if (cnt == GUARD_LAST) begin
              done_o <= 1'b1;
              phase  <= PH_IDLE;
            end else begin
              cnt <= nxt;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/expo_window_chk.sv
module expo_window_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       busy,
  input logic [3:0] pcode,
  input logic       integ,
  input logic       done
);
  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !integ);

  // R6
  steady_low_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && pcode == 4'd15) |-> !integ);

  // R2
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(integ) |-> $past(tick));

  // R5
  done_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(tick));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  done_after_close_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !integ);
endmodule

bind expo_window_ctrl expo_window_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .tick  (unit_rise),
  .busy  (busy),
  .pcode (pcode_q),
  .integ (integ_o),
  .done  (done_o)
);

// File: tb/expo_window_ctrl_tb.sv
`timescale 1ns/1ps
module expo_window_ctrl_tb;
  localparam int TP = 8;  // system cycles per unit tick

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       unit_clk_i = 1'b0;
  logic       ext_end_i = 1'b0;
  logic       ext_mode_i = 1'b0;
  logic [4:0] expo_code_i = 5'd0;
  logic [3:0] pulse_code_i = 4'd0;
  logic       integ_o;
  logic       done_o;

  int  ncyc = 0;
  int  total = 0;
  int  fails = 0;
  bit  ext_fire = 1'b0;
  int  ext_at = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  expo_window_ctrl u_dut (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .unit_clk_i   (unit_clk_i),
    .ext_end_i    (ext_end_i),
    .ext_mode_i   (ext_mode_i),
    .expo_code_i  (expo_code_i),
    .pulse_code_i (pulse_code_i),
    .integ_o      (integ_o),
    .done_o       (done_o)
  );

  function automatic int ticks_of(input int c);
    int t[32] = '{1, 2, 3, 4, 5, 7, 10, 14, 19, 23, 39, 67, 89, 100, 125, 150,
                  189, 200, 250, 300, 322, 400, 489, 739, 989, 1489, 1989,
                  4989, 9989, 14989, 29989, 59989};
    return t[c];
  endfunction

  function automatic int pulses_of(input int c);
    int p[16] = '{0, 1, 2, 3, 4, 5, 10, 20, 30, 40, 50, 75, 100, 150, 200, 0};
    return p[c];
  endfunction

  function automatic int level_at(input int pc, input int k);
    if (pc == 0)  return 1;
    if (pc == 15) return 0;
    return ((k % 2) == 1 && (k / 2) < pulses_of(pc)) ? 1 : 0;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    ncyc++;
    unit_clk_i = ((ncyc % TP) < (TP / 2));
    ext_end_i  = ext_fire && (ncyc >= ext_at);
  endtask

  // One exposure; ext_mode selects an end edge xt ticks into the window.
  task automatic run(input bit ext, input int ecode, input int pcode, input int xt,
                     input string req, input bit poke);
    int w, e, n_ticks, done_exp, first_exp, high_exp, rises_exp;
    int first_act, high_act, rises_act, done_act, done_cnt, limit, prevl, l, dur;
    logic prev_integ;
    while ((ncyc % TP) != 5) step();
    ext_mode_i   = ext;
    expo_code_i  = 5'(ecode);
    pulse_code_i = 4'(pcode);
    start_i      = 1'b1;
    step();
    start_i = 1'b0;
    w = (ncyc / TP + 1) * TP;
    e = w + 2 * TP;
    if (ext) begin
      ext_fire = 1'b1;
      ext_at   = e + xt * TP + 2;
      done_exp = e + (xt + 2) * TP + 3;
      n_ticks  = xt + 1;
    end else begin
      n_ticks  = ticks_of(ecode);
      done_exp = e + (n_ticks + 2) * TP + 3;
    end
    high_exp = 0; rises_exp = 0; prevl = 0; first_exp = -1;
    for (int k = 0; k < n_ticks; k++) begin
      l   = level_at(pcode, k);
      dur = (ext && k == xt) ? 2 : TP;
      if (l == 1 && prevl == 0) begin
        rises_exp++;
        if (first_exp < 0) first_exp = e + k * TP + 3;
      end
      high_exp += l * dur;
      prevl = l;
    end
    first_act = -1; high_act = 0; rises_act = 0; done_act = -1; done_cnt = 0;
    prev_integ = 1'b0;
    limit = done_exp + 3 * TP;
    while (ncyc < limit) begin
      step();
      if (poke && ncyc == e + TP + 1) begin
        expo_code_i  = 5'd31;
        pulse_code_i = 4'd15;
        ext_mode_i   = ~ext;
        start_i      = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      if (integ_o && !prev_integ) begin
        rises_act++;
        if (first_act < 0) first_act = ncyc;
      end
      if (integ_o) high_act++;
      if (done_o) begin
        done_cnt++;
        if (done_act < 0) done_act = ncyc;
      end
      prev_integ = integ_o;
    end
    start_i  = 1'b0;
    ext_fire = 1'b0;
    check("R2", "first rise cycle", first_act, first_exp);
    check(req, "high cycles", high_act, high_exp);
    check(req, "rising edges", rises_act, rises_exp);
    check("R5", "done cycle", done_act, done_exp);
    check(poke ? "R9" : "R5", "done count", done_cnt, 1);
  endtask

  initial begin
    repeat (5) step();
    check("R1", "integ in reset", int'(integ_o), 0);
    check("R1", "done in reset", int'(done_o), 0);
    rst = 1'b0;
    repeat (2 * TP) step();
    check("R1", "integ idle", int'(integ_o), 0);
    check("R1", "done idle", int'(done_o), 0);
    // R3: preset lengths with steady output
    for (int c = 0; c <= 13; c++) run(1'b0, c, 0, 0, "R3", 1'b0);
    // R6 / R7 / R8: every shape code over a 10-tick and a 39-tick window
    for (int p = 0; p < 16; p++) begin
      run(1'b0, 6, p, 0, (p == 0 || p == 15) ? "R6" : (pulses_of(p) > 5 ? "R8" : "R7"), 1'b0);
      run(1'b0, 10, p, 0, (p == 0 || p == 15) ? "R6" : (pulses_of(p) > 19 ? "R8" : "R7"), 1'b0);
    end
    // R8: one-tick window cannot fit any pulse
    run(1'b0, 0, 1, 0, "R8", 1'b0);
    // R4: external end, steady and pulsed
    run(1'b1, 0, 0, 3, "R4", 1'b0);
    run(1'b1, 0, 2, 5, "R4", 1'b0);
    run(1'b1, 31, 0, 7, "R4", 1'b0);
    // R9: start and mode changes during a running exposure
    run(1'b0, 8, 0, 0, "R9", 1'b1);
    run(1'b0, 6, 3, 0, "R9", 1'b1);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule